// File: doc/BRIEF.md
# SPI Register File with Interrupt Request

This block is the host-facing register set of an SPI controller. A 3-bit address and 16-bit data bus give the host access to a receive word (read-only), a transmit word (write-only), a status word, a control word and a slave-select mask. The serial shift engine sits beside it. The engine takes the buffered transmit word with a load strobe, reports that a transfer is running on a busy line, and delivers each received word with a valid strobe.

The block keeps the flags that describe the state of the two holding registers: transmit ready, transmitter empty, receive ready, and the two overrun errors with their summary error bit. Each interrupt-capable status bit has an enable at the same bit position of the control word. A single interrupt request is the OR of every status bit whose enable is set. One control bit forces the slave selects active. The slave-select mask goes to the engine as it is.

Top module: `spi_regfile`

## Requirements
- R1: A read (`bus_rd_en`=1) returns the addressed word on `bus_rdata` one cycle later, and `bus_rdata` is 0 in every cycle that follows a cycle without a read. Address 0 is the receive word, 2 is status, 3 is control and 5 is the select mask. Addresses 1, 4, 6 and 7 read 0.
- R2: After synchronous reset, status reads 0x0060 (transmit ready bit 6 and transmitter empty bit 5 set), control reads 0 and the select mask reads 0x0001.
- R3: A write to address 1 while transmit ready is 1 stores `bus_wdata[DATA_W-1:0]` on `tx_word`, raises `tx_full` and clears transmit ready (status bit 6) on the next cycle.
- R4: A write to address 1 while transmit ready is 0 sets transmit overrun (status bit 4) and leaves `tx_word` unchanged.
- R5: `eng_load` while `tx_full` is 1 sets transmit ready and clears transmitter empty (bit 5). Transmitter empty returns to 1 after any cycle in which `eng_busy` is 0 and no load is taken. `eng_load` while `tx_full` is 0 is ignored.
- R6: `eng_rx_valid` stores `eng_rx_data` as the receive word and sets receive ready (bit 7). A read of address 0 clears receive ready. If the read and an arrival fall in the same cycle, the read returns the old word, receive ready stays 1 and no overrun is flagged.
- R7: An arrival while receive ready is 1, with no read of address 0 in that cycle, sets receive overrun (bit 3), and the new word replaces the old one.
- R8: Status bit 8 is the OR of bits 3 and 4. Any write to address 2 clears both overrun bits, but an overrun event in the same cycle wins. Reading status changes nothing.
- R9: Control bits 3, 4, 6, 7, 8 and 10 are writable and all other control bits read 0. `ss_force` follows control bit 10.
- R10: `irq` is 1 exactly when some status bit at position 3, 4, 6, 7 or 8 and the control bit at the same position are both 1. It follows the register state, so it changes in the cycle after the event that caused the change.
- R11: Writes to addresses 0 and 4 change no register.
- R12: A write to address 5 loads `bus_wdata[NUM_SEL-1:0]` into the select mask, which drives `ss_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the read |
| eng_load | input | 1 | Engine moved the buffered word into its shifter |
| eng_busy | input | 1 | Engine transfer in progress |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| tx_word | output | DATA_W | Buffered transmit word |
| tx_full | output | 1 | Transmit holding register occupied |
| ss_mask | output | NUM_SEL | Slave-select mask |
| ss_force | output | 1 | Force selects active |
| irq | output | 1 | Interrupt request |

## Verification
Every effect of a bus write or an engine strobe shows up on the outputs in the cycle right after the clock edge that samples the stimulus. Read data needs one more register, so a read issued in cycle k is seen at cycle k+1. The bench drives inputs at the falling edge, and its reference model advances at the rising edge from those same inputs. It compares every output at the next falling edge, which is exactly one register stage after the stimulus. The directed reads hold their strobe for one cycle and sample on the following falling edge, against values worked out by hand.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

    localparam int BUS_W  = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_RXD  = 3'd0,
        ADR_TXD  = 3'd1,
        ADR_STAT = 3'd2,
        ADR_CTRL = 3'd3,
        ADR_RSVD = 3'd4,
        ADR_SEL  = 3'd5
    } reg_addr_e;

    localparam int B_ROE   = 3;
    localparam int B_TOE   = 4;
    localparam int B_TMT   = 5;
    localparam int B_TRDY  = 6;
    localparam int B_RRDY  = 7;
    localparam int B_ERR   = 8;
    localparam int B_FORCE = 10;

    localparam logic [BUS_W-1:0] IRQ_SRC_MASK =
        (BUS_W'(1) << B_ROE) | (BUS_W'(1) << B_TOE) | (BUS_W'(1) << B_TRDY) |
        (BUS_W'(1) << B_RRDY) | (BUS_W'(1) << B_ERR);
    localparam logic [BUS_W-1:0] CTRL_RW_MASK = IRQ_SRC_MASK | (BUS_W'(1) << B_FORCE);

    typedef struct packed {
        logic err;
        logic rrdy;
        logic trdy;
        logic tmt;
        logic toe;
        logic roe;
    } flags_t;

    typedef struct packed {
        logic wr_rxd;
        logic wr_txd;
        logic wr_stat;
        logic wr_ctrl;
        logic wr_sel;
        logic rd_rxd;
    } strobes_t;

    function automatic logic [BUS_W-1:0] pack_status(flags_t f);
        logic [BUS_W-1:0] w;
        w         = '0;
        w[B_ROE]  = f.roe;
        w[B_TOE]  = f.toe;
        w[B_TMT]  = f.tmt;
        w[B_TRDY] = f.trdy;
        w[B_RRDY] = f.rrdy;
        w[B_ERR]  = f.err;
        return w;
    endfunction

endpackage

// File: rtl/spi_tx_holder.sv
module spi_tx_holder #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_txd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr_err,
    input  logic              eng_load,
    input  logic              eng_busy,
    output logic              trdy,
    output logic              tmt,
    output logic              toe,
    output logic [DATA_W-1:0] word
);

    logic accept;
    logic overrun;
    logic taken;

    always_comb begin
        accept  = wr_txd && trdy;
        overrun = wr_txd && !trdy;
        taken   = eng_load && !trdy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trdy <= 1'b1;
            tmt  <= 1'b1;
            toe  <= 1'b0;
            word <= '0;
        end else begin
            if (accept) begin
                word <= wdata;
                trdy <= 1'b0;
            end else if (taken) begin
                trdy <= 1'b1;
            end

            if (overrun) begin
                toe <= 1'b1;
            end else if (clr_err) begin
                toe <= 1'b0;
            end

            if (taken) begin
                tmt <= 1'b0;
            end else if (!eng_busy) begin
                tmt <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_rx_holder.sv
module spi_rx_holder #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rd_rxd,
    input  logic              clr_err,
    output logic              rrdy,
    output logic              roe,
    output logic [DATA_W-1:0] word
);

    logic lost;

    always_comb begin
        lost = rx_valid && rrdy && !rd_rxd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rrdy <= 1'b0;
            roe  <= 1'b0;
            word <= '0;
        end else begin
            if (rx_valid) begin
                word <= rx_data;
                rrdy <= 1'b1;
            end else if (rd_rxd) begin
                rrdy <= 1'b0;
            end

            if (lost) begin
                roe <= 1'b1;
            end else if (clr_err) begin
                roe <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_irq_ctl.sv
module spi_irq_ctl
    import spi_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] status,
    output logic [BUS_W-1:0] ctrl,
    output logic             irq
);

    logic [BUS_W-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= wdata & CTRL_RW_MASK;
        end
    end

    always_comb begin
        pend = status & ctrl & IRQ_SRC_MASK;
        irq  = |pend;
    end

endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
    import spi_regs_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_SEL = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         bus_addr,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic               eng_load,
    input  logic               eng_busy,
    input  logic               eng_rx_valid,
    input  logic [DATA_W-1:0]  eng_rx_data,
    output logic [DATA_W-1:0]  tx_word,
    output logic               tx_full,
    output logic [NUM_SEL-1:0] ss_mask,
    output logic               ss_force,
    output logic               irq
);

    localparam int SEL_RST = 1;

    strobes_t         stb;
    flags_t           flags;
    logic [BUS_W-1:0] status_w;
    logic [BUS_W-1:0] ctrl_w;
    logic [BUS_W-1:0] rd_next;
    logic             st_trdy;
    logic             st_tmt;
    logic             st_toe;
    logic             st_rrdy;
    logic             st_roe;
    logic [DATA_W-1:0] rx_word;
    logic [NUM_SEL-1:0] sel_q;

    // Address decode
    always_comb begin
        stb         = '0;
        stb.wr_rxd  = bus_wr_en && (bus_addr == ADR_RXD);
        stb.wr_txd  = bus_wr_en && (bus_addr == ADR_TXD);
        stb.wr_stat = bus_wr_en && (bus_addr == ADR_STAT);
        stb.wr_ctrl = bus_wr_en && (bus_addr == ADR_CTRL);
        stb.wr_sel  = bus_wr_en && (bus_addr == ADR_SEL);
        stb.rd_rxd  = bus_rd_en && (bus_addr == ADR_RXD);
    end

    spi_tx_holder #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .wr_txd   (stb.wr_txd),
        .wdata    (bus_wdata[DATA_W-1:0]),
        .clr_err  (stb.wr_stat),
        .eng_load (eng_load),
        .eng_busy (eng_busy),
        .trdy     (st_trdy),
        .tmt      (st_tmt),
        .toe      (st_toe),
        .word     (tx_word)
    );

    spi_rx_holder #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (eng_rx_valid),
        .rx_data  (eng_rx_data),
        .rd_rxd   (stb.rd_rxd),
        .clr_err  (stb.wr_stat),
        .rrdy     (st_rrdy),
        .roe      (st_roe),
        .word     (rx_word)
    );

    always_comb begin
        flags.roe  = st_roe;
        flags.toe  = st_toe;
        flags.tmt  = st_tmt;
        flags.trdy = st_trdy;
        flags.rrdy = st_rrdy;
        flags.err  = st_roe | st_toe;
        status_w   = pack_status(flags);
    end

    spi_irq_ctl u_irq (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (stb.wr_ctrl),
        .wdata   (bus_wdata),
        .status  (status_w),
        .ctrl    (ctrl_w),
        .irq     (irq)
    );

    // Select mask: bit 0 comes out of reset set
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        localparam logic RST_V = (i == 0) ? 1'(SEL_RST) : 1'b0;
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[i] <= RST_V;
            end else if (stb.wr_sel) begin
                sel_q[i] <= bus_wdata[i];
            end
        end
    end

    // Read mux
    always_comb begin
        rd_next = '0;
        case (bus_addr)
            ADR_RXD:  rd_next[DATA_W-1:0]  = rx_word;
            ADR_STAT: rd_next              = status_w;
            ADR_CTRL: rd_next              = ctrl_w;
            ADR_SEL:  rd_next[NUM_SEL-1:0] = sel_q;
            default:  rd_next              = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd_en ? rd_next : '0;
        end
    end

    always_comb begin
        tx_full  = !st_trdy;
        ss_mask  = sel_q;
        ss_force = ctrl_w[B_FORCE];
    end

endmodule

// File: rtl/spi_regfile_chk.sv
module spi_regfile_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        bus_addr,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic              eng_rx_valid,
    input logic              tx_full,
    input logic [DATA_W-1:0] tx_word,
    input logic              rrdy,
    input logic              roe,
    input logic              toe
);

    logic wr_tx, wr_st, rd_rx;
    assign wr_tx = bus_wr_en && (bus_addr == 3'd1);
    assign wr_st = bus_wr_en && (bus_addr == 3'd2);
    assign rd_rx = bus_rd_en && (bus_addr == 3'd0);

    AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        wr_tx && !tx_full |=> tx_full); // R3

    AST_TX_DROP: assert property (@(posedge clk) disable iff (rst)
        wr_tx && tx_full |=> toe && $stable(tx_word)); // R4

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rd_rx && !eng_rx_valid |=> !rrdy); // R6

    AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        eng_rx_valid && rrdy && !rd_rx |=> roe); // R7

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        wr_st && !eng_rx_valid && !wr_tx |=> !roe && !toe); // R8

endmodule

bind spi_regfile spi_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr_en    (bus_wr_en),
    .bus_rd_en    (bus_rd_en),
    .eng_rx_valid (eng_rx_valid),
    .tx_full      (tx_full),
    .tx_word      (tx_word),
    .rrdy         (st_rrdy),
    .roe          (st_roe),
    .toe          (st_toe)
);

// File: tb/spi_regfile_test.sv
`timescale 1ns/1ps
module spi_regfile_test;

    localparam int DW = 8;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    bus_addr = '0;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          eng_load = 1'b0;
    logic          eng_busy = 1'b0;
    logic          eng_rx_valid = 1'b0;
    logic [DW-1:0] eng_rx_data = '0;
    logic [DW-1:0] tx_word;
    logic          tx_full;
    logic [NS-1:0] ss_mask;
    logic          ss_force;
    logic          irq;

    always #4 clk = ~clk;

    spi_regfile #(.DATA_W(DW), .NUM_SEL(NS)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_load(eng_load), .eng_busy(eng_busy), .eng_rx_valid(eng_rx_valid),
        .eng_rx_data(eng_rx_data), .tx_word(tx_word), .tx_full(tx_full),
        .ss_mask(ss_mask), .ss_force(ss_force), .irq(irq)
    );

    int total = 0;
    int fails = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit m_trdy, m_tmt, m_toe, m_rrdy, m_roe;
    bit [DW-1:0] m_tx, m_rx;
    bit [15:0]   m_ctrl, m_rd;
    bit [NS-1:0] m_sel;

    function automatic bit [15:0] m_status();
        bit [15:0] s = 0;
        s[3] = m_roe; s[4] = m_toe; s[5] = m_tmt;
        s[6] = m_trdy; s[7] = m_rrdy; s[8] = m_roe | m_toe;
        return s;
    endfunction

    function automatic bit [15:0] m_read(input bit [2:0] a);
        case (a)
            3'd0: return 16'(m_rx);
            3'd2: return m_status();
            3'd3: return m_ctrl;
            3'd5: return 16'(m_sel);
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_trdy = 1; m_tmt = 1; m_toe = 0; m_rrdy = 0; m_roe = 0;
            m_tx = 0; m_rx = 0; m_ctrl = 0; m_rd = 0; m_sel = 1;
        end else begin
            bit wtx, wst, rrx;
            wtx = bus_wr_en && bus_addr == 3'd1;
            wst = bus_wr_en && bus_addr == 3'd2;
            rrx = bus_rd_en && bus_addr == 3'd0;
            m_rd = bus_rd_en ? m_read(bus_addr) : 16'h0;
            if (wtx && !m_trdy) m_toe = 1; else if (wst) m_toe = 0;
            if (eng_load && !m_trdy) m_tmt = 0; else if (!eng_busy) m_tmt = 1;
            if (wtx && m_trdy) begin m_tx = bus_wdata[DW-1:0]; m_trdy = 0; end
            else if (eng_load && !m_trdy) m_trdy = 1;
            if (eng_rx_valid && m_rrdy && !rrx) m_roe = 1; else if (wst) m_roe = 0;
            if (eng_rx_valid) begin m_rx = eng_rx_data; m_rrdy = 1; end
            else if (rrx) m_rrdy = 0;
            if (bus_wr_en && bus_addr == 3'd3) m_ctrl = bus_wdata & 16'h05D8;
            if (bus_wr_en && bus_addr == 3'd5) m_sel = bus_wdata[NS-1:0];
        end
    end

    // Per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit m_irq;
            m_irq = |(m_status() & m_ctrl & 16'h01D8);
            chk(bus_rdata == m_rd, "R1 rdata", bus_rdata, m_rd);
            chk(irq == m_irq, "R10 irq", irq, m_irq);
            chk(tx_full == !m_trdy, "R3 tx_full", tx_full, !m_trdy);
            chk(tx_word == m_tx, "R3 tx_word", tx_word, m_tx);
            chk(ss_mask == m_sel, "R12 ss_mask", ss_mask, m_sel);
            chk(ss_force == m_ctrl[10], "R9 ss_force", ss_force, m_ctrl[10]);
        end
    end

    task automatic drive(input bit wr, input bit rd, input bit [2:0] a, input bit [15:0] d,
                         input bit ld, input bit busy, input bit rxv, input bit [DW-1:0] rxd);
        @(negedge clk);
        bus_wr_en = wr; bus_rd_en = rd; bus_addr = a; bus_wdata = d;
        eng_load = ld; eng_busy = busy; eng_rx_valid = rxv; eng_rx_data = rxd;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input bit [2:0] a, input bit [15:0] d);
        drive(1, 0, a, d, 0, 0, 0, 0);
        idle();
    endtask

    task automatic rd_chk(input bit [2:0] a, input bit [15:0] exp, input string tag);
        drive(0, 1, a, 0, 0, 0, 0, 0);
        idle();
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic rx(input bit [DW-1:0] d);
        drive(0, 0, 0, 0, 0, 0, 1, d);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        idle();

        // R2 reset state, R1 unreadable addresses
        rd_chk(3'd2, 16'h0060, "R2 status after reset");
        rd_chk(3'd3, 16'h0000, "R2 control after reset");
        rd_chk(3'd5, 16'h0001, "R2 select after reset");
        rd_chk(3'd1, 16'h0000, "R1 tx address reads zero");
        rd_chk(3'd4, 16'h0000, "R1 reserved reads zero");
        rd_chk(3'd7, 16'h0000, "R1 unmapped reads zero");

        // R9 control mask, R10 irq on transmit ready
        wr(3'd3, 16'hFFFF);
        rd_chk(3'd3, 16'h05D8, "R9 control writable bits");
        chk(ss_force == 1, "R9 force select", ss_force, 1);
        chk(irq == 1, "R10 irq on trdy", irq, 1);
        wr(3'd3, 16'h0000);
        chk(irq == 0, "R10 irq masked", irq, 0);

        // R3 accept, R4 overrun
        wr(3'd1, 16'h01A5);
        chk(tx_word == 8'hA5 && tx_full, "R3 word stored", tx_word, 8'hA5);
        rd_chk(3'd2, 16'h0020, "R3 trdy cleared");
        wr(3'd1, 16'h0033);
        rd_chk(3'd2, 16'h0130, "R4 toe and R8 err set");
        chk(tx_word == 8'hA5, "R4 word kept", tx_word, 8'hA5);

        // R5 load and empty
        drive(0, 0, 0, 0, 1, 1, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 0, 0);
        drive(0, 1, 3'd2, 0, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 0, 0);
        chk(bus_rdata == 16'h0150, "R5 busy after load", bus_rdata, 16'h0150);
        idle();
        rd_chk(3'd2, 16'h0170, "R5 empty after busy drops");
        drive(0, 0, 0, 0, 1, 0, 0, 0);
        idle();
        rd_chk(3'd2, 16'h0170, "R5 load ignored when empty");

        // R8 status write clears
        wr(3'd2, 16'h0000);
        rd_chk(3'd2, 16'h0060, "R8 errors cleared");
        rd_chk(3'd2, 16'h0060, "R8 status read no side effect");

        // R6 receive
        rx(8'h5C);
        rd_chk(3'd2, 16'h00E0, "R6 rrdy set");
        rd_chk(3'd0, 16'h005C, "R6 receive word");
        rd_chk(3'd2, 16'h0060, "R6 rrdy cleared by read");

        // R7 overrun
        rx(8'h11);
        rx(8'h22);
        rd_chk(3'd2, 16'h01E8, "R7 roe set");
        wr(3'd3, 16'h0008);
        chk(irq == 1, "R10 irq on roe", irq, 1);
        rd_chk(3'd0, 16'h0022, "R7 newest word kept");
        wr(3'd2, 16'h0000);
        chk(irq == 0, "R10 irq after clear", irq, 0);

        // R11 ignored writes
        wr(3'd0, 16'hFFFF);
        rd_chk(3'd0, 16'h0022, "R11 rx write ignored");
        wr(3'd4, 16'hFFFF);
        rd_chk(3'd2, 16'h0060, "R11 reserved write ignored");
        rd_chk(3'd3, 16'h0008, "R11 control untouched");

        // R12 select mask
        wr(3'd5, 16'hFFFA);
        rd_chk(3'd5, 16'h000A, "R12 select mask");
        chk(ss_mask == 4'hA, "R12 ss_mask pins", ss_mask, 4'hA);

        // R6 simultaneous read and arrival
        rx(8'h41);
        drive(0, 1, 3'd0, 0, 0, 0, 1, 8'h42);
        idle();
        chk(bus_rdata == 16'h0041, "R6 read returns old word", bus_rdata, 16'h0041);
        rd_chk(3'd2, 16'h00E0, "R6 no overrun on read collision");

        // R8 overrun wins over status write
        drive(1, 0, 3'd2, 0, 0, 0, 1, 8'h43);
        idle();
        rd_chk(3'd2, 16'h01E8, "R8 overrun beats clear");
        wr(3'd2, 16'h0000);
        rd_chk(3'd0, 16'h0043, "R7 overwrite word");

        // Mixed pseudo-random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 2);
            drive(op == 1, op == 2, 3'($urandom_range(0, 7)), 16'($urandom),
                  1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0), DW'($urandom));
        end
        idle();
        idle();

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule